// File: doc/BRIEF.md
# External Bus Cycle Sequencer

This block is the master-side engine that runs a single beat on an external, non-multiplexed bus. A requester gives it a chip-select index, an address, write data and a direction. The sequencer then drives a one-clock transfer-start strobe and asserts the addressed active-low chip select. It waits for an acknowledge, captures read data on the acknowledge edge and negates the chip select. It spends one more clock, plus any programmed hold clocks, keeping the address and write data valid before it accepts the next request.

Every chip select has its own settings: a wait-state count, an internal auto-acknowledge enable, a count of extra setup clocks inserted between the strobe and chip-select assertion, and a count of extra hold clocks appended after negation. With auto-acknowledge on, the beat ends after the programmed wait states and the acknowledge pin is ignored. With it off, the beat waits for the external slave. The configuration inputs must stay constant while a beat that uses them is in progress.

Top module: `bus_beat_seq`

## Requirements
- R1: Out of reset, `req_ready` is 1, every `bus_cs_n` line is 1, `bus_ts_n` is 1, `bus_oe` is 0 and `beat_done` is 0.
- R2: A request is taken on the rising edge where `req_valid` and `req_ready` are both 1. The next clock is the start phase, in which `bus_ts_n` is 0 for exactly that one clock and all chip selects stay high.
- R3: With N extra setup clocks configured for the selected chip select, N clocks lie between the start phase and the first clock with that chip select low. During those clocks `bus_ts_n` is 1 and all chip selects are high.
- R4: Only line `bus_cs_n[i]`, with i the latched `req_cs` index, goes low. It stays low for the whole acknowledge phase and for exactly one clock after it.
- R5: With auto-acknowledge enabled and W wait states, the acknowledge phase lasts W+1 clocks whatever `bus_ta` does.
- R6: With auto-acknowledge disabled, the acknowledge phase lasts until the first clock of that phase in which `bus_ta` is 1. It ends at the rising edge that closes that clock.
- R7: `rd_data` takes the value on `bus_din` at the rising edge that ends the acknowledge phase, and it holds that value while `beat_done` is 1.
- R8: `beat_done` is 1 for exactly one clock. That clock is the first one after chip-select negation, and all chip selects are high in it.
- R9: `bus_oe` is 1 on writes (`req_write` = 1) from the first chip-select clock through the clock after negation and any extra hold clocks. It is 0 on reads and in all other clocks.
- R10: `bus_addr` and `bus_rnw` (1 = read) keep the latched request values from the start phase to the end of hold, whatever the request inputs do.
- R11: With H extra hold clocks configured, `req_ready` returns to 1 H clocks after the `beat_done` clock. No request is taken while `req_ready` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Beat request present |
| req_ready | output | 1 | Sequencer idle, request taken this edge if valid |
| req_cs | input | CS_W | Chip-select index of the request |
| req_addr | input | ADDR_W | Beat address |
| req_wdata | input | DATA_W | Write data |
| req_write | input | 1 | 1 = write, 0 = read |
| cfg_wait | input | NUM_CS*WS_W | Wait states per chip select |
| cfg_autoack | input | NUM_CS | Auto-acknowledge enable per chip select |
| cfg_setup | input | NUM_CS*SH_W | Extra setup clocks per chip select |
| cfg_hold | input | NUM_CS*SH_W | Extra hold clocks per chip select |
| bus_addr | output | ADDR_W | Bus address |
| bus_ts_n | output | 1 | Transfer-start strobe, active low |
| bus_cs_n | output | NUM_CS | Chip selects, active low |
| bus_rnw | output | 1 | Direction, 1 = read |
| bus_oe | output | 1 | Write data output enable |
| bus_dout | output | DATA_W | Write data to bus |
| bus_din | input | DATA_W | Read data from bus |
| bus_ta | input | 1 | Transfer acknowledge from slave, active high |
| rd_data | output | DATA_W | Captured read data |
| beat_done | output | 1 | One-clock completion pulse |

## Verification
The bench builds the block with four chip selects, three-bit wait-state fields and two-bit setup and hold fields. Random beats can therefore reach the largest wait count (7) and the largest setup and hold extensions (3) as well as zero on every field. External-acknowledge delays up to five clocks test the slave-paced path against the internal counter. In auto-acknowledge beats the acknowledge pin is driven randomly, to show that it has no effect. The request inputs are scrambled while a beat is in progress, which shows that the latched address and direction are kept and that no second request slips in.

// File: rtl/bbs_pkg.sv
// Shared types for the external bus beat sequencer.
package bbs_pkg;
    // Phases of one bus beat; order matters only for readability.
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_S0    = 3'd1,
        ST_SETUP = 3'd2,
        ST_S1    = 3'd3,
        ST_S2    = 3'd4,
        ST_S3    = 3'd5,
        ST_HOLD  = 3'd6
    } bbs_state_e;
endpackage

// File: rtl/bbs_cfg_sel.sv
// Selects the per-chip-select timing fields for the latched chip-select index.
// Assumes NUM_CS is a power of two so every index value names a real slot.
module bbs_cfg_sel #(
    parameter int NUM_CS = 4,
    parameter int WS_W   = 3,
    parameter int SH_W   = 2,
    localparam int CS_W  = $clog2(NUM_CS)
) (
    input  logic [CS_W-1:0]        cs_idx,
    input  logic [NUM_CS*WS_W-1:0] cfg_wait,
    input  logic [NUM_CS-1:0]      cfg_autoack,
    input  logic [NUM_CS*SH_W-1:0] cfg_setup,
    input  logic [NUM_CS*SH_W-1:0] cfg_hold,
    output logic [WS_W-1:0]        sel_wait,
    output logic                   sel_autoack,
    output logic [SH_W-1:0]        sel_setup,
    output logic [SH_W-1:0]        sel_hold
);
    logic [WS_W-1:0] wait_arr  [NUM_CS];
    logic [SH_W-1:0] setup_arr [NUM_CS];
    logic [SH_W-1:0] hold_arr  [NUM_CS];

    // Unpack the flat configuration buses into per-slot arrays.
    for (genvar g = 0; g < NUM_CS; g++) begin : g_slot
        assign wait_arr[g]  = cfg_wait[g*WS_W +: WS_W];
        assign setup_arr[g] = cfg_setup[g*SH_W +: SH_W];
        assign hold_arr[g]  = cfg_hold[g*SH_W +: SH_W];
    end

    // Index the slot of the active chip select.
    always_comb begin
        sel_wait    = wait_arr[cs_idx];
        sel_autoack = cfg_autoack[cs_idx];
        sel_setup   = setup_arr[cs_idx];
        sel_hold    = hold_arr[cs_idx];
    end
endmodule

// File: rtl/bbs_phase_cnt.sv
// Down counter shared by the setup, wait-state and hold phases.
// Load has priority over decrement; the counter never wraps below zero.
module bbs_phase_cnt #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             is_zero
);
    logic [CNT_W-1:0] cnt_q;

    // Count register: load a phase length or step toward zero.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (dec && cnt_q != '0)
            cnt_q <= cnt_q - CNT_W'(1);
    end

    assign is_zero = (cnt_q == '0);
endmodule

// File: rtl/bbs_fsm.sv
// Beat phase controller: start, optional setup, acknowledge, one more select
// clock, release clock, optional hold. Assumes the timing inputs are steady
// for the length of the beat that uses them.
module bbs_fsm #(
    parameter int CNT_W = 3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  ta,
    input  logic                  autoack,
    input  logic [CNT_W-1:0]      wait_n,
    input  logic [CNT_W-1:0]      setup_n,
    input  logic [CNT_W-1:0]      hold_n,
    input  logic                  cnt_zero,
    output bbs_pkg::bbs_state_e   state,
    output logic                  accept,
    output logic                  capture,
    output logic                  cnt_load,
    output logic [CNT_W-1:0]      cnt_val,
    output logic                  cnt_dec
);
    import bbs_pkg::*;

    bbs_state_e st_q, st_d;
    logic       ack_now;

    // The phase-ending acknowledge: internal counter or external pin.
    assign ack_now = autoack ? cnt_zero : ta;

    // Next-phase and counter-control decode.
    always_comb begin
        st_d     = st_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        cnt_dec  = 1'b0;
        capture  = 1'b0;
        unique case (st_q)
            ST_IDLE: if (req_valid) st_d = ST_S0;
            ST_S0: begin
                cnt_load = 1'b1;
                if (setup_n != '0) begin
                    st_d    = ST_SETUP;
                    cnt_val = setup_n - CNT_W'(1);
                end else begin
                    st_d    = ST_S1;
                    cnt_val = wait_n;
                end
            end
            ST_SETUP: begin
                if (cnt_zero) begin
                    st_d     = ST_S1;
                    cnt_load = 1'b1;
                    cnt_val  = wait_n;
                end else begin
                    cnt_dec = 1'b1;
                end
            end
            ST_S1: begin
                if (ack_now) begin
                    st_d    = ST_S2;
                    capture = 1'b1;
                end else begin
                    cnt_dec = autoack;
                end
            end
            ST_S2: st_d = ST_S3;
            ST_S3: begin
                if (hold_n != '0) begin
                    st_d     = ST_HOLD;
                    cnt_load = 1'b1;
                    cnt_val  = hold_n - CNT_W'(1);
                end else begin
                    st_d = ST_IDLE;
                end
            end
            ST_HOLD: begin
                if (cnt_zero) st_d = ST_IDLE;
                else          cnt_dec = 1'b1;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    assign state  = st_q;
    assign accept = (st_q == ST_IDLE) && req_valid;
endmodule

// File: rtl/bbs_beat_regs.sv
// Holds the request fields for the beat in flight and the captured read data.
// Fields are loaded only on acceptance, so request inputs may change freely
// while a beat runs.
module bbs_beat_regs #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CS_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic              capture,
    input  logic [CS_W-1:0]   in_cs,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [DATA_W-1:0] in_wdata,
    input  logic              in_write,
    input  logic [DATA_W-1:0] in_rdata,
    output logic [CS_W-1:0]   cs_q,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              write_q,
    output logic [DATA_W-1:0] rdata_q
);
    // Request latch, loaded once per beat.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q    <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            write_q <= 1'b0;
        end else if (accept) begin
            cs_q    <= in_cs;
            addr_q  <= in_addr;
            wdata_q <= in_wdata;
            write_q <= in_write;
        end
    end

    // Read data capture on the acknowledge edge.
    always_ff @(posedge clk) begin
        if (!rst_n)       rdata_q <= '0;
        else if (capture) rdata_q <= in_rdata;
    end
endmodule

// File: rtl/bus_beat_seq.sv
// Top of the external bus beat sequencer. Runs one beat at a time and
// decodes all bus strobes from the registered phase, so no bus output has a
// combinational path from an input.
module bus_beat_seq #(
    parameter int NUM_CS = 4,
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int WS_W   = 3,
    parameter int SH_W   = 2,
    localparam int CS_W  = $clog2(NUM_CS),
    localparam int CNT_W = (WS_W > SH_W) ? WS_W : SH_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [CS_W-1:0]        req_cs,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [DATA_W-1:0]      req_wdata,
    input  logic                   req_write,
    input  logic [NUM_CS*WS_W-1:0] cfg_wait,
    input  logic [NUM_CS-1:0]      cfg_autoack,
    input  logic [NUM_CS*SH_W-1:0] cfg_setup,
    input  logic [NUM_CS*SH_W-1:0] cfg_hold,
    output logic [ADDR_W-1:0]      bus_addr,
    output logic                   bus_ts_n,
    output logic [NUM_CS-1:0]      bus_cs_n,
    output logic                   bus_rnw,
    output logic                   bus_oe,
    output logic [DATA_W-1:0]      bus_dout,
    input  logic [DATA_W-1:0]      bus_din,
    input  logic                   bus_ta,
    output logic [DATA_W-1:0]      rd_data,
    output logic                   beat_done
);
    import bbs_pkg::*;

    bbs_state_e      state;
    logic            accept, capture, cnt_load, cnt_dec, cnt_zero;
    logic [CNT_W-1:0] cnt_val;
    logic [CS_W-1:0] cs_q;
    logic            write_q;
    logic [WS_W-1:0] sel_wait;
    logic            sel_autoack;
    logic [SH_W-1:0] sel_setup, sel_hold;
    logic            sel_active;

    bbs_beat_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CS_W(CS_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .accept(accept), .capture(capture),
        .in_cs(req_cs), .in_addr(req_addr), .in_wdata(req_wdata),
        .in_write(req_write), .in_rdata(bus_din),
        .cs_q(cs_q), .addr_q(bus_addr), .wdata_q(bus_dout),
        .write_q(write_q), .rdata_q(rd_data)
    );

    bbs_cfg_sel #(.NUM_CS(NUM_CS), .WS_W(WS_W), .SH_W(SH_W)) u_cfg (
        .cs_idx(cs_q), .cfg_wait(cfg_wait), .cfg_autoack(cfg_autoack),
        .cfg_setup(cfg_setup), .cfg_hold(cfg_hold),
        .sel_wait(sel_wait), .sel_autoack(sel_autoack),
        .sel_setup(sel_setup), .sel_hold(sel_hold)
    );

    bbs_phase_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .load(cnt_load), .load_val(cnt_val),
        .dec(cnt_dec), .is_zero(cnt_zero)
    );

    bbs_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .ta(bus_ta),
        .autoack(sel_autoack), .wait_n(CNT_W'(sel_wait)),
        .setup_n(CNT_W'(sel_setup)), .hold_n(CNT_W'(sel_hold)),
        .cnt_zero(cnt_zero), .state(state), .accept(accept),
        .capture(capture), .cnt_load(cnt_load), .cnt_val(cnt_val),
        .cnt_dec(cnt_dec)
    );

    // Chip select window covers the acknowledge phase and the clock after.
    assign sel_active = (state == ST_S1) || (state == ST_S2);

    // One active-low select line per slot, low only for the latched index.
    for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
        assign bus_cs_n[g] = !(sel_active && (cs_q == CS_W'(g)));
    end

    // Phase-decoded strobes and status.
    always_comb begin
        req_ready = (state == ST_IDLE);
        bus_ts_n  = (state != ST_S0);
        beat_done = (state == ST_S3);
        bus_rnw   = !write_q;
        bus_oe    = write_q && ((state == ST_S1) || (state == ST_S2) ||
                                (state == ST_S3) || (state == ST_HOLD));
    end
endmodule

// File: rtl/bus_beat_seq_chk.sv
// Protocol checker for the beat sequencer, bound to every instance of the top.
module bus_beat_seq_chk #(
    parameter int NUM_CS = 4,
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_ts_n,
    input logic [NUM_CS-1:0] bus_cs_n,
    input logic              bus_rnw,
    input logic              bus_oe,
    input logic              beat_done
);
    AST_ACCEPT_STARTS: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_ready) |=> !bus_ts_n) else $error("accept without start"); // R2
    AST_START_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n) !bus_ts_n |=> bus_ts_n) else $error("start too long"); // R2
    AST_START_NO_CS: assert property (@(posedge clk) disable iff (!rst_n) !bus_ts_n |-> (&bus_cs_n)) else $error("select during start"); // R2
    AST_CS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(~bus_cs_n)) else $error("several selects"); // R4
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) beat_done |=> !beat_done) else $error("done too long"); // R8
    AST_DONE_CS_OFF: assert property (@(posedge clk) disable iff (!rst_n) beat_done |-> (&bus_cs_n)) else $error("select in done"); // R8
    AST_READ_NO_OE: assert property (@(posedge clk) disable iff (!rst_n) bus_rnw |-> !bus_oe) else $error("oe on read"); // R9
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n) (!req_ready && $past(!req_ready)) |-> $stable(bus_addr)) else $error("addr moved"); // R10
    AST_IDLE_NO_CS: assert property (@(posedge clk) disable iff (!rst_n) req_ready |-> (&bus_cs_n && bus_ts_n)) else $error("bus active in idle"); // R11
endmodule

bind bus_beat_seq bus_beat_seq_chk #(.NUM_CS(NUM_CS), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .bus_addr(bus_addr), .bus_ts_n(bus_ts_n), .bus_cs_n(bus_cs_n),
    .bus_rnw(bus_rnw), .bus_oe(bus_oe), .beat_done(beat_done)
);

// File: tb/bus_beat_seq_tb_top.sv
`timescale 1ns/1ps
module bus_beat_seq_tb_top;
    localparam int NCS = 4;
    localparam int AW  = 32;
    localparam int DW  = 32;
    localparam int WSW = 3;
    localparam int SHW = 2;
    localparam int CSW = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0, req_ready, req_write = 1'b0;
    logic [CSW-1:0] req_cs = '0;
    logic [AW-1:0] req_addr = '0, bus_addr;
    logic [DW-1:0] req_wdata = '0, bus_dout, bus_din = '0, rd_data;
    logic [NCS*WSW-1:0] cfg_wait = '0;
    logic [NCS-1:0] cfg_autoack = '0, bus_cs_n;
    logic [NCS*SHW-1:0] cfg_setup = '0, cfg_hold = '0;
    logic bus_ts_n, bus_rnw, bus_oe, bus_ta = 1'b0, beat_done;

    int errors = 0, checks = 0, cycles = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    bus_beat_seq #(.NUM_CS(NCS), .ADDR_W(AW), .DATA_W(DW), .WS_W(WSW), .SH_W(SHW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_cs(req_cs), .req_addr(req_addr), .req_wdata(req_wdata), .req_write(req_write),
        .cfg_wait(cfg_wait), .cfg_autoack(cfg_autoack), .cfg_setup(cfg_setup), .cfg_hold(cfg_hold),
        .bus_addr(bus_addr), .bus_ts_n(bus_ts_n), .bus_cs_n(bus_cs_n), .bus_rnw(bus_rnw),
        .bus_oe(bus_oe), .bus_dout(bus_dout), .bus_din(bus_din), .bus_ta(bus_ta),
        .rd_data(rd_data), .beat_done(beat_done)
    );

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at cycle %0d: actual=%0h expected=%0h", tag, cycles, act, exp);
        end
    endtask

    // Phase code of clock k after acceptance: 0 start,1 setup,2 ack,3 select tail,4 release,5 hold,6 idle.
    function automatic int phase_of(int k, int su, int n1, int hd);
        if (k == 0) return 0;
        k -= 1;
        if (k < su) return 1;
        k -= su;
        if (k < n1) return 2;
        k -= n1;
        if (k == 0) return 3;
        if (k == 1) return 4;
        k -= 2;
        if (k < hd) return 5;
        return 6;
    endfunction

    function automatic logic [NCS-1:0] exp_cs(int ph, int cs);
        if (ph == 2 || ph == 3) return ~(NCS'(1) << cs);
        return '1;
    endfunction

    task automatic run_beat(input int cs, input logic [AW-1:0] addr, input logic [DW-1:0] wd,
                            input bit wr, input int ws, input bit aa, input int su, input int hd,
                            input int extd);
        int n1, total, j;
        logic [DW-1:0] exp_rd;
        exp_rd = '0;
        n1 = aa ? ws + 1 : extd + 1;
        total = 1 + su + n1 + 2 + hd;
        cfg_wait[cs*WSW +: WSW]  = WSW'(ws);
        cfg_autoack[cs]          = aa;
        cfg_setup[cs*SHW +: SHW] = SHW'(su);
        cfg_hold[cs*SHW +: SHW]  = SHW'(hd);
        req_valid = 1'b1; req_cs = CSW'(cs); req_addr = addr; req_wdata = wd; req_write = wr;
        @(posedge clk);
        @(negedge clk);
        // Scramble the request inputs while busy (R10, R11).
        req_addr = ~addr; req_wdata = ~wd; req_write = ~wr; req_cs = CSW'(cs + 1);
        for (int k = 0; k <= total; k++) begin
            int ph;
            string cstag;
            ph = phase_of(k, su, n1, hd);
            cstag = (ph == 1) ? "R3" : (ph == 2) ? (aa ? "R5" : "R6") : "R4";
            chk(bus_ts_n == (ph != 0), "R2 start strobe", 64'(bus_ts_n), 64'(ph != 0));
            chk(bus_cs_n == exp_cs(ph, cs), cstag, 64'(bus_cs_n), 64'(exp_cs(ph, cs)));
            chk(bus_oe == (wr && ph >= 2 && ph <= 5), "R9 output enable", 64'(bus_oe), 64'(wr && ph >= 2 && ph <= 5));
            chk(beat_done == (ph == 4), "R8 done pulse", 64'(beat_done), 64'(ph == 4));
            chk(req_ready == (ph == 6), "R11 ready", 64'(req_ready), 64'(ph == 6));
            chk(bus_addr == addr && bus_rnw == !wr, "R10 addr/dir", {31'b0, bus_rnw, bus_addr}, {31'b0, !wr, addr});
            if (ph == 2 && !wr) chk(1'b1, "R7 ack window", 0, 0);
            if (ph == 4 && !wr) chk(rd_data == exp_rd, "R7 read data", 64'(rd_data), 64'(exp_rd));
            if (ph == 4 && wr) chk(bus_dout == wd, "R9 write data", 64'(bus_dout), 64'(wd));
            if (ph == 6) req_valid = 1'b0;
            // Drive this clock's inputs.
            bus_din = $urandom;
            j = k - 1 - su;
            if (ph == 2) begin
                bus_ta = aa ? 1'($urandom) : (j == extd);
                if (j == n1 - 1) exp_rd = bus_din;
            end else begin
                bus_ta = aa ? 1'($urandom) : 1'b0;
            end
            @(negedge clk);
        end
        bus_ta = 1'b0;
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                chk(1'b0, "watchdog", 64'(cycles), 64'd150000);
                finish_run();
            end
        end
    end

    initial begin : main
        int seed;
        seed = $urandom(32'd7321);
        repeat (3) @(negedge clk);
        // R1: reset values while held and just after release.
        chk(req_ready && &bus_cs_n && bus_ts_n && !bus_oe && !beat_done, "R1 reset", 
            {59'b0, req_ready, &bus_cs_n, bus_ts_n, bus_oe, beat_done}, 64'b11100);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && &bus_cs_n && bus_ts_n && !bus_oe && !beat_done, "R1 after reset",
            {59'b0, req_ready, &bus_cs_n, bus_ts_n, bus_oe, beat_done}, 64'b11100);
        // Directed corners.
        run_beat(0, 32'h1000_0004, 32'hA5A5_0001, 0, 0, 1, 0, 0, 0); // R5 minimal read
        run_beat(3, 32'h2000_00F0, 32'hDEAD_BEEF, 1, 7, 1, 3, 3, 0); // R3 R5 R11 max write
        run_beat(1, 32'h3000_0010, 32'h0, 0, 7, 0, 0, 0, 0);         // R6 immediate slave ack
        run_beat(2, 32'h4000_0020, 32'h0, 0, 0, 0, 2, 1, 5);         // R6 slow slave
        run_beat(2, 32'h5000_0030, 32'h1234_5678, 1, 4, 1, 1, 2, 0); // R5 pin ignored
        // Random beats.
        for (int i = 0; i < 160; i++) begin
            run_beat(int'($urandom_range(0, NCS-1)), $urandom, $urandom, 1'($urandom),
                     int'($urandom_range(0, 7)), 1'($urandom), int'($urandom_range(0, 3)),
                     int'($urandom_range(0, 3)), int'($urandom_range(0, 5)));
        end
        finish_run();
    end
endmodule